// File: doc/BRIEF.md
# Vector Byte Permute, Merge and Select Unit

This block rearranges the data held in 128-bit vectors, each treated as sixteen 8-bit elements. It takes up to three source vectors and produces one result vector, in one of four operations. Permute works as a full crossbar: every result byte may be any one of the 32 bytes of the first two sources, in any order and with repetition, as directed by the third source. Merge-high and merge-low interleave elements from matching halves of the first two sources, at byte, halfword or word width. Select builds each result bit from one of the first two sources, as the third source directs bit by bit.

A request is presented with `in_valid` high for one clock. Its result is registered and appears with `out_valid` on the next cycle, so a new request can be accepted every cycle. The operation codes are `OP_PERM`, `OP_MRGH`, `OP_MRGL` and `OP_SEL`. The unit has no other control state: between requests the result register holds its last value.

Top module: `vperm_unit`

## Requirements
- R1: Byte 0 of every vector is bits 127:120 and byte 15 is bits 7:0. `mode` encodes 0 = permute, 1 = merge-high, 2 = merge-low, 3 = select.
- R2: While `rst_n` is low, and after it is released until the first request, `out_valid` is 0 and `result` is all zeros.
- R3: In permute, result byte i is taken from the 32-byte pool {src_a, src_b}, at the index given by bits 4:0 of control byte i of `src_c`. Indices 0–15 select src_a bytes 0–15 and indices 16–31 select src_b bytes 0–15. Any index may appear in several result bytes.
- R4: In permute, bits 7:5 of each control byte have no effect on the result.
- R5: In merge-high, the element width is set by `size`: 0 = byte, 1 = halfword, 2 and 3 = word. Element j of the upper half (bytes 0–7) of src_a goes to result element 2j, and element j of the upper half of src_b goes to result element 2j+1.
- R6: Merge-low follows the R5 rules but takes its elements from the lower halves (bytes 8–15) of the two sources.
- R7: In select, each result bit equals the src_b bit where the matching `src_c` bit is 1 and the src_a bit where it is 0.
- R8: `size` has no effect in permute and select, and `src_c` has no effect in either merge.
- R9: While `in_valid` is low, `result` keeps its value, whatever the other inputs do.
- R10: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high. The result of each request is presented in that cycle, and requests may arrive on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe; inputs sampled this cycle |
| mode | input | 2 | Operation code (R1) |
| size | input | 2 | Merge element width |
| src_a | input | 128 | First source vector |
| src_b | input | 128 | Second source vector |
| src_c | input | 128 | Permute control or select mask |
| out_valid | output | 1 | Result valid, one cycle after request |
| result | output | 128 | Registered result vector |

## Verification
The bench targets several permute cases: control bytes that cross from the first source into the second, repeated indices, and control bytes with their upper three bits set. A design that used too many index bits, or that reversed the byte order, would place the wrong bytes in the result. For merge it tries every `size` code in both halves, including code 3. A unit that swapped source order or took the wrong half would misplace elements at one granularity only. The bench also changes the unused inputs, alters the inputs while `in_valid` is low, and runs requests back to back, which exposes a result register that loads without a request or a strobe that lags by one cycle.

// File: rtl/vperm_pkg.sv
package vperm_pkg;

    typedef enum logic [1:0] {
        OP_PERM = 2'd0,
        OP_MRGH = 2'd1,
        OP_MRGL = 2'd2,
        OP_SEL  = 2'd3
    } vperm_op_e;

    typedef enum logic [1:0] {
        EW_BYTE  = 2'd0,
        EW_HALF  = 2'd1,
        EW_WORD  = 2'd2,
        EW_WORD3 = 2'd3
    } vperm_ew_e;

endpackage

// File: rtl/vperm_xbar.sv
module vperm_xbar #(
    parameter int NBYTES = 16
) (
    input  logic [NBYTES*8-1:0] pa,
    input  logic [NBYTES*8-1:0] pb,
    input  logic [NBYTES*8-1:0] ctl,
    output logic [NBYTES*8-1:0] y
);
    localparam int VW = NBYTES * 8;
    localparam int PN = 2 * NBYTES;
    localparam int IW = $clog2(PN);

    logic [7:0] pool [PN];

    genvar k;
    generate
        for (k = 0; k < NBYTES; k++) begin : g_pool
            assign pool[k]          = pa[VW-8-8*k +: 8];
            assign pool[NBYTES + k] = pb[VW-8-8*k +: 8];
        end
    endgenerate

    genvar i;
    generate
        for (i = 0; i < NBYTES; i++) begin : g_lane
            logic [IW-1:0] idx;
            assign idx = ctl[VW-8-8*i +: IW];
            assign y[VW-8-8*i +: 8] = pool[idx];
        end
    endgenerate
endmodule

// File: rtl/vperm_merge.sv
module vperm_merge #(
    parameter int NBYTES = 16,
    parameter bit LOW    = 1'b0
) (
    input  logic [NBYTES*8-1:0] pa,
    input  logic [NBYTES*8-1:0] pb,
    input  logic [1:0]          ew,
    output logic [NBYTES*8-1:0] y
);
    import vperm_pkg::*;

    localparam int VW    = NBYTES * 8;
    localparam int HB    = NBYTES / 2;
    localparam int BASE  = LOW ? HB : 0;
    localparam int NGRAN = 3;

    logic [VW-1:0] cand [NGRAN];

    genvar g, j;
    generate
        for (g = 0; g < NGRAN; g++) begin : g_gran
            localparam int EB = 1 << g;
            localparam int EW = 8 * EB;
            localparam int NE = HB / EB;
            logic [VW-1:0] v;
            for (j = 0; j < NE; j++) begin : g_elem
                localparam int SRC = BASE + j * EB;
                localparam int DA  = 2 * j * EB;
                localparam int DB  = DA + EB;
                assign v[VW-EW-8*DA +: EW] = pa[VW-EW-8*SRC +: EW];
                assign v[VW-EW-8*DB +: EW] = pb[VW-EW-8*SRC +: EW];
            end
            assign cand[g] = v;
        end
    endgenerate

    always_comb begin
        unique case (vperm_ew_e'(ew))
            EW_BYTE:  y = cand[0];
            EW_HALF:  y = cand[1];
            EW_WORD,
            EW_WORD3: y = cand[2];
            default:  y = cand[2];
        endcase
    end
endmodule

// File: rtl/vperm_bitsel.sv
module vperm_bitsel #(
    parameter int NBYTES = 16
) (
    input  logic [NBYTES*8-1:0] pa,
    input  logic [NBYTES*8-1:0] pb,
    input  logic [NBYTES*8-1:0] mask,
    output logic [NBYTES*8-1:0] y
);
    always_comb begin
        y = (pa & ~mask) | (pb & mask);
    end
endmodule

// File: rtl/vperm_unit.sv
module vperm_unit #(
    parameter int NBYTES = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          mode,
    input  logic [1:0]          size,
    input  logic [NBYTES*8-1:0] src_a,
    input  logic [NBYTES*8-1:0] src_b,
    input  logic [NBYTES*8-1:0] src_c,
    output logic                out_valid,
    output logic [NBYTES*8-1:0] result
);
    import vperm_pkg::*;

    localparam int VW = NBYTES * 8;

    logic [VW-1:0] perm_y;
    logic [VW-1:0] mrgh_y;
    logic [VW-1:0] mrgl_y;
    logic [VW-1:0] sel_y;
    logic [VW-1:0] nxt_result;
    vperm_op_e     op;

    assign op = vperm_op_e'(mode);

    vperm_xbar #(.NBYTES(NBYTES)) u_xbar (
        .pa  (src_a),
        .pb  (src_b),
        .ctl (src_c),
        .y   (perm_y)
    );

    vperm_merge #(.NBYTES(NBYTES), .LOW(1'b0)) u_mrgh (
        .pa (src_a),
        .pb (src_b),
        .ew (size),
        .y  (mrgh_y)
    );

    vperm_merge #(.NBYTES(NBYTES), .LOW(1'b1)) u_mrgl (
        .pa (src_a),
        .pb (src_b),
        .ew (size),
        .y  (mrgl_y)
    );

    vperm_bitsel #(.NBYTES(NBYTES)) u_sel (
        .pa   (src_a),
        .pb   (src_b),
        .mask (src_c),
        .y    (sel_y)
    );

    always_comb begin
        unique case (op)
            OP_PERM: nxt_result = perm_y;
            OP_MRGH: nxt_result = mrgh_y;
            OP_MRGL: nxt_result = mrgl_y;
            OP_SEL:  nxt_result = sel_y;
            default: nxt_result = perm_y;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt_result;
            end
        end
    end
endmodule

// File: rtl/vperm_unit_chk.sv
module vperm_unit_chk #(
    parameter int NBYTES = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [1:0]          mode,
    input logic [1:0]          size,
    input logic [NBYTES*8-1:0] src_a,
    input logic [NBYTES*8-1:0] src_b,
    input logic [NBYTES*8-1:0] src_c,
    input logic                out_valid,
    input logic [NBYTES*8-1:0] result
);
    localparam int VW = NBYTES * 8;
    localparam int IW = $clog2(2 * NBYTES);

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R7
    sel_zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd3 && src_c == '0) |=> result == $past(src_a));

    // R7
    sel_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd3 && src_c == '1) |=> result == $past(src_b));

    // R5
    mrgh_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd1) |=> result[VW-1 -: 8] == $past(src_a[VW-1 -: 8]));

    // R6
    mrgl_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd2) |=> result[7:0] == $past(src_b[7:0]));

    // R3
    perm_zero_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 2'd0 && src_c[VW-8 +: IW] == '0)
            |=> result[VW-1 -: 8] == $past(src_a[VW-1 -: 8]));
endmodule

bind vperm_unit vperm_unit_chk #(.NBYTES(NBYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .mode      (mode),
    .size      (size),
    .src_a     (src_a),
    .src_b     (src_b),
    .src_c     (src_c),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/vperm_unit_test.sv
module vperm_unit_test;
    localparam int NB = 16;
    localparam int VW = NB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [1:0]    size = 2'd0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic [VW-1:0] src_c = '0;
    logic          out_valid;
    logic [VW-1:0] result;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    vperm_unit #(.NBYTES(NB)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .mode      (mode),
        .size      (size),
        .src_a     (src_a),
        .src_b     (src_b),
        .src_c     (src_c),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [VW-1:0] model(input logic [1:0] md, input logic [1:0] sz,
                                            input logic [VW-1:0] a, input logic [VW-1:0] b,
                                            input logic [VW-1:0] c);
        logic [7:0]    pool [32];
        logic [VW-1:0] r;
        logic [7:0]    cb;
        int            eb;
        r = '0;
        for (int k = 0; k < 16; k++) begin
            pool[k]      = a[VW-1-8*k -: 8];
            pool[16 + k] = b[VW-1-8*k -: 8];
        end
        if (md == 2'd0) begin
            for (int i = 0; i < 16; i++) begin
                cb = c[VW-1-8*i -: 8];
                r[VW-1-8*i -: 8] = pool[cb[4:0]];
            end
        end else if (md == 2'd3) begin
            r = (a & ~c) | (b & c);
        end else begin
            eb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
            for (int p = 0; p < 16; p++) begin
                int el, off, srcb;
                el   = p / eb;
                off  = p % eb;
                srcb = ((md == 2'd2) ? 8 : 0) + (el / 2) * eb + off;
                r[VW-1-8*p -: 8] = (el % 2 == 0) ? pool[srcb] : pool[16 + srcb];
            end
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    function automatic logic [VW-1:0] ctl_seq(input int start, input int step, input logic [7:0] hi);
        logic [VW-1:0] c;
        for (int i = 0; i < 16; i++) begin
            c[VW-1-8*i -: 8] = hi | 8'((start + step * i) & 31);
        end
        return c;
    endfunction

    task automatic check_vec(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: result %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: out_valid %b expected %b", tag, got, exp);
        end
    endtask

    // called at a negedge; drives a request and checks it one edge later
    task automatic run_vec(input string tag, input logic [1:0] md, input logic [1:0] sz,
                           input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] c);
        logic [VW-1:0] exp;
        exp      = model(md, sz, a, b, c);
        in_valid = 1'b1;
        mode     = md;
        size     = sz;
        src_a    = a;
        src_b    = b;
        src_c    = c;
        @(negedge clk);
        check_bit({tag, "/R10"}, out_valid, 1'b1);
        check_vec(tag, result, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [VW-1:0] a, b, c, held;
        logic [VW-1:0] ident;
        void'($urandom(32'd1207));
        a = 128'h00112233_44556677_8899AABB_CCDDEEFF;
        b = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;

        repeat (3) @(negedge clk);
        // R2: reset state
        check_bit("R2 in reset", out_valid, 1'b0);
        check_vec("R2 in reset", result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R2 after release", out_valid, 1'b0);
        check_vec("R2 after release", result, '0);

        // R3/R1 permute: identity, second source, reversed, repetition
        ident = ctl_seq(0, 1, 8'h00);
        run_vec("R3 ident", 2'd0, 2'd0, a, b, ident);
        run_vec("R3 srcb", 2'd0, 2'd0, a, b, ctl_seq(16, 1, 8'h00));
        run_vec("R3 reverse", 2'd0, 2'd0, a, b, ctl_seq(31, -1, 8'h00));
        run_vec("R3 repeat", 2'd0, 2'd0, a, b, {16{8'd31}});
        run_vec("R3 cross", 2'd0, 2'd0, a, b, ctl_seq(8, 3, 8'h00));
        // R4: upper control bits ignored
        run_vec("R4 hibits", 2'd0, 2'd0, a, b, ctl_seq(0, 1, 8'hE0));
        run_vec("R4 hibits2", 2'd0, 2'd0, a, b, ctl_seq(16, 1, 8'hA0));
        // R8: size ignored in permute and select
        run_vec("R8 perm sz1", 2'd0, 2'd1, a, b, ident);
        run_vec("R8 perm sz3", 2'd0, 2'd3, a, b, ident);
        run_vec("R8 sel sz2", 2'd3, 2'd2, a, b, 128'h0F0F_0000_FFFF_1234_5678_9ABC_DEF0_8001);

        // R5/R6 merge at every size code
        for (int s = 0; s < 4; s++) begin
            run_vec("R5 mrgh", 2'd1, 2'(s), a, b, '0);
            run_vec("R6 mrgl", 2'd2, 2'(s), a, b, '0);
            // R8: control vector ignored in merge
            run_vec("R8 mrg ctl", 2'd1, 2'(s), a, b, '1);
        end

        // R7 select masks
        run_vec("R7 mask0", 2'd3, 2'd0, a, b, '0);
        run_vec("R7 mask1", 2'd3, 2'd0, a, b, '1);
        run_vec("R7 alt", 2'd3, 2'd0, a, b, {32{4'hA}});

        // R9/R10: idle with changing inputs
        in_valid = 1'b0;
        held = model(2'd3, 2'd0, a, b, {32{4'hA}});
        for (int k = 0; k < 4; k++) begin
            mode  = 2'(k);
            size  = 2'(k);
            src_a = rnd128();
            src_b = rnd128();
            src_c = rnd128();
            @(negedge clk);
            check_bit("R10 idle", out_valid, 1'b0);
            check_vec("R9 hold", result, held);
        end

        // random back-to-back mix
        for (int n = 0; n < 600; n++) begin
            logic [1:0] md, sz;
            md = 2'($urandom_range(0, 3));
            sz = 2'($urandom_range(0, 3));
            a  = rnd128();
            b  = rnd128();
            c  = rnd128();
            case (md)
                2'd0:    run_vec("R3 rand", md, sz, a, b, c);
                2'd1:    run_vec("R5 rand", md, sz, a, b, c);
                2'd2:    run_vec("R6 rand", md, sz, a, b, c);
                default: run_vec("R7 rand", md, sz, a, b, c);
            endcase
            if (n % 37 == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
                check_bit("R10 gap", out_valid, 1'b0);
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        check_bit("R10 end", out_valid, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule